// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Acknowledge

This block collects up to eight device interrupt lines into one request toward an upstream interrupt router. Devices raise lines by pulsing a post strobe with a bit vector, and withdraw them with a clear strobe. The host reaches the block over a small register bus. It programs a mask byte, where a 1 blocks the line. It reads back the raw pending byte. It retires a serviced line by writing that line's number to the acknowledge address. Priority, vectoring and cascading are left to other logic. A second, dormant controller slot is decoded so that host software written for a two-bank arrangement still works. That slot reads as zero and ignores writes.

The mask is held internally in inverted form, as an enable vector. A two-state request machine tracks whether any enabled line is pending. It re-evaluates on every post, clear, acknowledge and mask write. The states are `REQ_IDLE` and `REQ_ACTIVE`. The `RAISE` transition goes from `REQ_IDLE` to `REQ_ACTIVE` when an enabled pending line appears. The `DROP` transition goes from `REQ_ACTIVE` to `REQ_IDLE` when none remains. The machine holds its state otherwise. Each transition also emits a one-cycle edge notification.

Register addresses on `bus_addr`: 0 primary status, 1 primary mask, 2 primary acknowledge, 3 secondary status, 4 secondary mask, 5 secondary acknowledge. Addresses 6 and 7 read as zero and ignore writes.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, pending is 0x00, a mask read returns 0xFF (all lines masked), and `irq_req`, `irq_rise` and `irq_fall` are low.
- R2: A write to address 1 stores the complement of the byte as the enable vector. A later read of address 1 returns the byte as written.
- R3: `irq_req` is high exactly when pending AND enable is non-zero. It updates at the same clock edge as the post, clear, acknowledge or mask write that changes that condition.
- R4: A post strobe ORs `post_vec` into pending and leaves already-pending bits set.
- R5: A clear strobe removes the bits of `clr_vec` from pending.
- R6: A write to address 2 clears the pending bit whose index is `bus_wdata[3:0]`. Indices 8 to 15 clear nothing, and `bus_wdata[7:4]` is ignored.
- R7: When a post and an acknowledge or clear hit the same bit in the same cycle, the bit ends up set.
- R8: A read of address 0 returns the raw pending byte, zero-extended to 64 bits on `rd_data`.
- R9: Address 3 reads 0x00. Writes to addresses 4 and 5 change neither pending, the mask read-back nor `irq_req`.
- R10: `irq_rise` pulses for one cycle on the cycle `irq_req` goes high, and `irq_fall` pulses for one cycle on the cycle it goes low.
- R11: `rd_valid` is high for exactly one cycle, the cycle after `rd_en`. `rd_data` then shows the state from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_en | input | 1 | Device post strobe |
| post_vec | input | 8 | Lines to set |
| clr_en | input | 1 | Device clear strobe |
| clr_vec | input | 8 | Lines to clear |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Host write data |
| rd_data | output | 64 | Read data, zero-extended |
| rd_valid | output | 1 | Read data valid |
| irq_req | output | 1 | Level request to the upstream router |
| irq_rise | output | 1 | One-cycle pulse on request assertion |
| irq_fall | output | 1 | One-cycle pulse on request release |

## Verification
A corrupted pending or enable bit shows up at `irq_req` at the very edge that updates it, because the request is derived from next-state values. It also shows up at the next status or mask read, one cycle after `rd_en`. A machine state that disagrees with pending and enable either leaves the request stuck or produces a missing or extra edge pulse within one cycle. The bench therefore compares `irq_req` and the edge pulses right after each stimulus, and it reads back pending and mask after every step that could disturb them.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_t;

    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADR_STATUS     = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MASK       = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_ACK        = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_SEC_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_SEC_MASK   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_SEC_ACK    = 3'd5;
endpackage

// File: rtl/irq_agg_pending.sv
module irq_agg_pending #(
    parameter int unsigned LINES = 8,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_en,
    input  logic [LINES-1:0] post_vec,
    input  logic             clr_en,
    input  logic [LINES-1:0] clr_vec,
    input  logic             ack_en,
    input  logic [IDX_W-1:0] ack_idx,
    output logic [LINES-1:0] pend_q,
    output logic [LINES-1:0] pend_d
);
    logic [LINES-1:0] ack_hit;
    logic [LINES-1:0] set_bits;
    logic [LINES-1:0] drop_bits;

    // one comparator per line; indices beyond LINES match nothing
    for (genvar i = 0; i < LINES; i++) begin : g_ack
        assign ack_hit[i] = ack_en && (ack_idx == IDX_W'(i));
    end

    assign set_bits  = post_en ? post_vec : '0;
    assign drop_bits = (clr_en ? clr_vec : '0) | ack_hit;

    // post has priority over acknowledge and clear on the same bit
    always_comb begin
        pend_d = (pend_q & ~drop_bits) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R4: posted bits are present after the edge
    assert_post_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        post_en |=> ((pend_q & $past(post_vec)) == $past(post_vec)));

    // R7: a post always survives a simultaneous drop request
    assert_post_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en && clr_en) |=> ((pend_q & $past(post_vec & clr_vec)) == $past(post_vec & clr_vec)));

    // R5: cleared bits that were not re-posted are gone
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !post_en) |=> ((pend_q & $past(clr_vec)) == '0));
endmodule

// File: rtl/irq_agg_enable.sv
module irq_agg_enable #(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic [LINES-1:0] mask_byte,
    output logic [LINES-1:0] en_q,
    output logic [LINES-1:0] en_d,
    output logic [LINES-1:0] mask_view
);
    always_comb begin
        en_d = mask_wr ? ~mask_byte : en_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign mask_view = ~en_q;

    // R2: the enable vector holds the complement of the written mask
    assert_mask_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (en_q == ~$past(mask_byte)));

    // R2: without a mask write the enable vector holds
    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(en_q));
endmodule

// File: rtl/irq_agg_reqfsm.sv
module irq_agg_reqfsm
    import irq_agg_pkg::*;
#(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pend_d,
    input  logic [LINES-1:0] en_d,
    input  logic [LINES-1:0] pend_q,
    input  logic [LINES-1:0] en_q,
    output logic             irq_req,
    output logic             irq_rise,
    output logic             irq_fall
);
    req_state_t state_q, state_d;
    logic       live_d;

    assign live_d = |(pend_d & en_d);

    // next-state logic: RAISE and DROP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   if (live_d)  state_d = REQ_ACTIVE;
            REQ_ACTIVE: if (!live_d) state_d = REQ_IDLE;
            default:    state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    // output process: level and edge notifications
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rise <= 1'b0;
            irq_fall <= 1'b0;
        end else begin
            irq_rise <= (state_q == REQ_IDLE)   && (state_d == REQ_ACTIVE);
            irq_fall <= (state_q == REQ_ACTIVE) && (state_d == REQ_IDLE);
        end
    end

    assign irq_req = (state_q == REQ_ACTIVE);

    // R3: request level agrees with stored pending and enable
    assert_req_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (|(pend_q & en_q)));

    // R10: a rise pulse marks a fresh assertion
    assert_rise_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rise |-> (irq_req && !$past(irq_req)));

    // R10: a fall pulse marks a fresh release
    assert_fall_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fall |-> (!irq_req && $past(irq_req)));

    // R10: pulses never overlap
    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_rise && irq_fall));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned LINES = 8,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned RD_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_en,
    input  logic [LINES-1:0]  post_vec,
    input  logic              clr_en,
    input  logic [LINES-1:0]  clr_vec,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [RD_W-1:0]   rd_data,
    output logic              rd_valid,
    output logic              irq_req,
    output logic              irq_rise,
    output logic              irq_fall
);
    localparam int unsigned PAD_W = RD_W - LINES;

    logic             mask_wr, ack_wr;
    logic [LINES-1:0] pend_q, pend_d, en_q, en_d, mask_view;
    logic [LINES-1:0] rd_sel;

    // secondary mask and acknowledge writes decode to nothing
    assign mask_wr = wr_en && (bus_addr == ADR_MASK);
    assign ack_wr  = wr_en && (bus_addr == ADR_ACK);

    irq_agg_pending #(.LINES(LINES), .IDX_W(IDX_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .post_en  (post_en),
        .post_vec (post_vec),
        .clr_en   (clr_en),
        .clr_vec  (clr_vec),
        .ack_en   (ack_wr),
        .ack_idx  (bus_wdata[IDX_W-1:0]),
        .pend_q   (pend_q),
        .pend_d   (pend_d)
    );

    irq_agg_enable #(.LINES(LINES)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_wr   (mask_wr),
        .mask_byte (bus_wdata),
        .en_q      (en_q),
        .en_d      (en_d),
        .mask_view (mask_view)
    );

    irq_agg_reqfsm #(.LINES(LINES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_d   (pend_d),
        .en_d     (en_d),
        .pend_q   (pend_q),
        .en_q     (en_q),
        .irq_req  (irq_req),
        .irq_rise (irq_rise),
        .irq_fall (irq_fall)
    );

    always_comb begin
        unique case (bus_addr)
            ADR_STATUS: rd_sel = pend_q;
            ADR_MASK:   rd_sel = mask_view;
            default:    rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= {{PAD_W{1'b0}}, rd_sel};
        end
    end

    // R11: valid is a single-cycle echo of the read strobe
    assert_rd_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(rd_en));

    // R8: read data never carries bits above the byte
    assert_rd_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[RD_W-1:LINES] == '0));

    // R9: secondary writes leave the enable vector alone
    assert_sec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (bus_addr == ADR_SEC_MASK)) |=> $stable(en_q));
endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_en = 1'b0, clr_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  post_vec = '0, clr_vec = '0, bus_wdata = '0;
    logic [2:0]  bus_addr = '0;
    logic [63:0] rd_data;
    logic        rd_valid, irq_req, irq_rise, irq_fall;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n),
        .post_en(post_en), .post_vec(post_vec),
        .clr_en(clr_en), .clr_vec(clr_vec),
        .wr_en(wr_en), .rd_en(rd_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .irq_req(irq_req), .irq_rise(irq_rise), .irq_fall(irq_fall)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every returned read
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected read data", rd_data, 64'h0);
            end else begin
                automatic logic [63:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input logic [63:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; bus_addr = a;
        step();
        rd_en = 1'b0;
        check(rd_valid == 1'b1, "R11 valid one cycle after strobe", 64'(rd_valid), 64'h1);
        step();
        check(rd_valid == 1'b0, "R11 valid lasts one cycle", 64'(rd_valid), 64'h0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic post(input logic [7:0] v);
        post_en = 1'b1; post_vec = v;
        step();
        post_en = 1'b0;
    endtask

    task automatic clr(input logic [7:0] v);
        clr_en = 1'b1; clr_vec = v;
        step();
        clr_en = 1'b0;
    endtask

    task automatic req_is(input bit r, input bit rise, input bit fall, input string t);
        check(irq_req == r,     {t, " level"}, 64'(irq_req),  64'(r));
        check(irq_rise == rise, {t, " rise"},  64'(irq_rise), 64'(rise));
        check(irq_fall == fall, {t, " fall"},  64'(irq_fall), 64'(fall));
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        req_is(1'b0, 1'b0, 1'b0, "R1 reset");
        rd(3'd0, 64'h00, "R1 pending cleared");
        rd(3'd1, 64'hFF, "R1 mask all set");

        post(8'h05);
        req_is(1'b0, 1'b0, 1'b0, "R3 masked post keeps request low");
        rd(3'd0, 64'h05, "R4 R8 pending after post");
        post(8'h01);
        rd(3'd0, 64'h05, "R4 repost keeps bits");

        wr(3'd1, 8'hFE);
        req_is(1'b1, 1'b1, 1'b0, "R3 R10 mask write raises");
        step();
        req_is(1'b1, 1'b0, 1'b0, "R10 rise lasts one cycle");
        rd(3'd1, 64'hFE, "R2 mask read-back");

        wr(3'd2, 8'hF0);
        req_is(1'b0, 1'b0, 1'b1, "R6 R10 ack of line 0 releases");
        rd(3'd0, 64'h04, "R6 ack clears bit 0 only");
        wr(3'd2, 8'h09);
        rd(3'd0, 64'h04, "R6 out-of-range index clears nothing");

        wr(3'd1, 8'hFB);
        req_is(1'b1, 1'b1, 1'b0, "R3 enable line 2 raises");
        clr(8'h04);
        req_is(1'b0, 1'b0, 1'b1, "R5 clear releases");
        rd(3'd0, 64'h00, "R5 pending after clear");

        // post against simultaneous ack and clear on line 2
        post_en = 1'b1; post_vec = 8'h0C; clr_en = 1'b1; clr_vec = 8'h04;
        wr_en = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h02;
        step();
        post_en = 1'b0; clr_en = 1'b0; wr_en = 1'b0;
        req_is(1'b1, 1'b1, 1'b0, "R7 post wins");
        rd(3'd0, 64'h0C, "R7 pending after collision");

        wr(3'd4, 8'h00);
        wr(3'd5, 8'h03);
        req_is(1'b1, 1'b0, 1'b0, "R9 secondary writes inert");
        rd(3'd0, 64'h0C, "R9 pending unchanged");
        rd(3'd1, 64'hFB, "R9 mask unchanged");
        rd(3'd3, 64'h00, "R9 secondary status zero");

        wr(3'd1, 8'hFF);
        req_is(1'b0, 1'b0, 1'b1, "R3 masking all releases");
        post(8'h80);
        wr(3'd1, 8'h7F);
        req_is(1'b1, 1'b1, 1'b0, "R3 line 7 raises");
        rd(3'd0, 64'h0000_0000_0000_008C, "R8 zero-extended status");

        step();
        check(exp_q.size() == 0, "R11 all reads returned", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule